// File: doc/BRIEF.md
# RAID P/Q Parity Generator

This block computes RAID parity over up to eight equal-length byte streams that arrive side by side, one beat at a time. A beat carries `LANES` bytes of every source. For each beat the block forms the plain XOR parity P. It also forms the Reed-Solomon syndrome Q, which is the XOR of every source byte multiplied by that source's 8-bit coefficient in GF(2^8). The field uses the reducing polynomial x^8+x^4+x^3+x^2+1 (0x11D). The results appear on the output streams one clock after the beat.

A command is accepted in one cycle. It carries:
- an opcode,
- a source count,
- separate P and Q suppress flags,
- eight packed coefficients,
- one extra coefficient used only by the update operation.

Five opcodes are valid:
- Two generate parity: XOR only, or P plus Q.
- Two check parity that already exists against extra input streams and report mismatch flags at completion. They write nothing.
- One folds a single new source into an old P and an old Q.

Two obsolete opcodes, and every other opcode, complete at once with an error.

The controller has three states. IDLE waits for a command. STREAM takes beats. FINISH raises `done` for one cycle. The transitions are:
- IDLE to STREAM on accepting a command that has work.
- IDLE to FINISH on accepting an erroneous command, or a generate command with every output suppressed.
- STREAM to FINISH on a beat marked last.
- FINISH to IDLE always.

Top module: `pq_parity_gen`

## Requirements
- R1: After reset `busy`, `done`, `err`, both mismatch flags and both output valids are 0.
- R2: Opcode 0x87 writes P as the XOR of sources 0 to `cmd_cnt` (the count is encoded as sources minus one). P appears on `p_out` with `p_out_valid` in the cycle after the beat is taken, and `q_out_valid` stays 0.
- R3: Opcode 0x89 writes P as in R2 and writes Q as the XOR over sources 0 to `cmd_cnt` of coefficient times source in GF(2^8) with polynomial 0x11D. Source s uses `cmd_coef[8s+7:8s]`. Source s, lane l sits at `beat_src[(s*LANES+l)*8 +: 8]`.
- R4: Sources with an index above `cmd_cnt` have no effect on P or Q, whatever their data.
- R5: `cmd_pdis` suppresses `p_out_valid` and `cmd_qdis` suppresses `q_out_valid`. A generate or update command that ends up with no output at all goes straight to FINISH, so `done` is high in the cycle after acceptance.
- R6: Opcodes 0x88 (P only) and 0x8A (P and Q) compare the computed parity with `beat_oldp` and `beat_oldq` and raise no output valid. `p_mismatch` and `q_mismatch` are reported only while `done` is high, and each is set if any beat differed in a part that is not suppressed.
- R7: Opcode 0x8B ignores `cmd_cnt` and `cmd_coef`. It writes new P as `beat_oldp` XOR source 0, and new Q as `beat_oldq` XOR (`cmd_upd_coef` times source 0).
- R8: Opcodes 0x85 and 0x86, and any opcode not listed in R2, R3, R6 or R7, go straight to FINISH with `err` high together with `done`, and produce no output.
- R9: `busy` is high from acceptance until `done`, and `done` lasts one cycle. `done` rises in the same cycle as the outputs of the last beat. A command offered while `busy` is high is ignored.
- R10: A beat offered while the block is not in STREAM is ignored and raises no output valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered; taken when idle |
| cmd_op | input | 8 | Opcode |
| cmd_cnt | input | $clog2(NSRC) | Number of sources minus one |
| cmd_pdis | input | 1 | Suppress P |
| cmd_qdis | input | 1 | Suppress Q |
| cmd_coef | input | NSRC*8 | Per-source Q coefficients |
| cmd_upd_coef | input | 8 | Coefficient for the update opcode |
| busy | output | 1 | Command in progress |
| beat_valid | input | 1 | Beat offered |
| beat_last | input | 1 | Final beat of the command |
| beat_src | input | NSRC*LANES*8 | Source bytes, source-major |
| beat_oldp | input | LANES*8 | Old or expected P stream |
| beat_oldq | input | LANES*8 | Old or expected Q stream |
| p_out | output | LANES*8 | P result |
| p_out_valid | output | 1 | P result valid |
| q_out | output | LANES*8 | Q result |
| q_out_valid | output | 1 | Q result valid |
| done | output | 1 | Completion pulse |
| err | output | 1 | Rejected opcode, valid with done |
| p_mismatch | output | 1 | P check failed, valid with done |
| q_mismatch | output | 1 | Q check failed, valid with done |

## Verification
The bench builds the block with NSRC=8 and LANES=2. Eight sources let it walk every source count, with junk data on the unused sources. Two lanes let a sweep of 256 update commands of 128 beats cover every coefficient times every byte value, 65536 field products in all, against a multiplier coded independently in the bench. Generate and check commands run across all counts, across every suppress combination, and with P or Q corrupted in chosen beats.

// File: rtl/pq_pkg.sv
package pq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STREAM,
        ST_FINISH
    } pq_state_e;

    typedef enum logic [2:0] {
        M_XOR_GEN,
        M_XOR_CHK,
        M_PQ_GEN,
        M_PQ_CHK,
        M_UPD,
        M_BAD
    } pq_mode_e;

    function automatic pq_mode_e op_to_mode(input logic [7:0] op);
        pq_mode_e m;
        case (op)
            8'h87:   m = M_XOR_GEN;
            8'h88:   m = M_XOR_CHK;
            8'h89:   m = M_PQ_GEN;
            8'h8A:   m = M_PQ_CHK;
            8'h8B:   m = M_UPD;
            default: m = M_BAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pq_gf_mul.sv
module pq_gf_mul #(
    parameter logic [7:0] POLY_LOW = 8'h1D
) (
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] y
);

    logic [7:0] sh;

    // shift-and-add multiply, reducing after every doubling
    always_comb begin
        y  = 8'h00;
        sh = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) y = y ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? POLY_LOW : 8'h00);
        end
    end

endmodule

// File: rtl/pq_lane.sv
module pq_lane #(
    parameter int         NSRC     = 8,
    parameter logic [7:0] POLY_LOW = 8'h1D
) (
    input  logic [NSRC*8-1:0] src,
    input  logic [NSRC*8-1:0] coef,
    input  logic [NSRC-1:0]   en,
    input  logic [7:0]        base_p,
    input  logic [7:0]        base_q,
    output logic [7:0]        p,
    output logic [7:0]        q
);

    logic [NSRC*8-1:0] prod;

    for (genvar s = 0; s < NSRC; s++) begin : g_mul
        pq_gf_mul #(.POLY_LOW(POLY_LOW)) u_mul (
            .a (src[s*8 +: 8]),
            .b (coef[s*8 +: 8]),
            .y (prod[s*8 +: 8])
        );
    end

    always_comb begin
        p = base_p;
        q = base_q;
        for (int s = 0; s < NSRC; s++) begin
            if (en[s]) begin
                p = p ^ src[s*8 +: 8];
                q = q ^ prod[s*8 +: 8];
            end
        end
    end

endmodule

// File: rtl/pq_parity_gen.sv
module pq_parity_gen
    import pq_pkg::*;
#(
    parameter int         NSRC     = 8,
    parameter int         LANES    = 4,
    parameter logic [7:0] POLY_LOW = 8'h1D,
    localparam int        CNTW     = $clog2(NSRC),
    localparam int        BW       = LANES * 8,
    localparam int        CW       = NSRC * 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [7:0]         cmd_op,
    input  logic [CNTW-1:0]    cmd_cnt,
    input  logic               cmd_pdis,
    input  logic               cmd_qdis,
    input  logic [CW-1:0]      cmd_coef,
    input  logic [7:0]         cmd_upd_coef,
    output logic               busy,
    input  logic               beat_valid,
    input  logic               beat_last,
    input  logic [NSRC*BW-1:0] beat_src,
    input  logic [BW-1:0]      beat_oldp,
    input  logic [BW-1:0]      beat_oldq,
    output logic [BW-1:0]      p_out,
    output logic               p_out_valid,
    output logic [BW-1:0]      q_out,
    output logic               q_out_valid,
    output logic               done,
    output logic               err,
    output logic               p_mismatch,
    output logic               q_mismatch
);

    pq_state_e         state_q, state_n;
    pq_mode_e          mode_q, cmd_mode;
    logic              pdis_q, qdis_q, err_q, pmis_q, qmis_q;
    logic [CW-1:0]     coef_q, coef_n;
    logic [NSRC-1:0]   en_q, en_n;
    logic              accept, cmd_empty, beat_take;
    logic              use_q, writes, checks, fold, want_p, want_q;
    logic [BW-1:0]     p_calc, q_calc;

    assign cmd_mode  = op_to_mode(cmd_op);
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign beat_take = beat_valid && (state_q == ST_STREAM);

    // a generate command whose outputs are all suppressed has nothing to do
    always_comb begin
        unique case (cmd_mode)
            M_XOR_GEN:      cmd_empty = cmd_pdis;
            M_PQ_GEN, M_UPD: cmd_empty = cmd_pdis && cmd_qdis;
            default:        cmd_empty = 1'b0;
        endcase
    end

    always_comb begin
        for (int i = 0; i < NSRC; i++) en_n[i] = (i <= int'(cmd_cnt));
        coef_n = cmd_coef;
        if (cmd_mode == M_UPD) begin
            en_n   = NSRC'(1);
            coef_n = {{(CW-8){1'b0}}, cmd_upd_coef};
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)
                state_n = (cmd_mode == M_BAD || cmd_empty) ? ST_FINISH : ST_STREAM;
            ST_STREAM: if (beat_valid && beat_last)
                state_n = ST_FINISH;
            ST_FINISH: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // command capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= M_BAD;
            pdis_q <= 1'b1;
            qdis_q <= 1'b1;
            err_q  <= 1'b0;
            coef_q <= '0;
            en_q   <= '0;
        end else if (accept) begin
            mode_q <= cmd_mode;
            pdis_q <= cmd_pdis;
            qdis_q <= cmd_qdis;
            err_q  <= (cmd_mode == M_BAD);
            coef_q <= coef_n;
            en_q   <= en_n;
        end
    end

    assign use_q  = (mode_q == M_PQ_GEN) || (mode_q == M_PQ_CHK) || (mode_q == M_UPD);
    assign writes = (mode_q == M_XOR_GEN) || (mode_q == M_PQ_GEN) || (mode_q == M_UPD);
    assign checks = (mode_q == M_XOR_CHK) || (mode_q == M_PQ_CHK);
    assign fold   = (mode_q == M_UPD);
    assign want_p = !pdis_q;
    assign want_q = !qdis_q && use_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CW-1:0] lane_src;
        for (genvar s = 0; s < NSRC; s++) begin : g_pick
            assign lane_src[s*8 +: 8] = beat_src[(s*LANES + l)*8 +: 8];
        end
        pq_lane #(.NSRC(NSRC), .POLY_LOW(POLY_LOW)) u_lane (
            .src    (lane_src),
            .coef   (coef_q),
            .en     (en_q),
            .base_p (fold ? beat_oldp[l*8 +: 8] : 8'h00),
            .base_q (fold ? beat_oldq[l*8 +: 8] : 8'h00),
            .p      (p_calc[l*8 +: 8]),
            .q      (q_calc[l*8 +: 8])
        );
    end

    // result and check registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_out       <= '0;
            q_out       <= '0;
            p_out_valid <= 1'b0;
            q_out_valid <= 1'b0;
            pmis_q      <= 1'b0;
            qmis_q      <= 1'b0;
        end else begin
            p_out_valid <= beat_take && writes && want_p;
            q_out_valid <= beat_take && writes && want_q;
            if (beat_take) begin
                p_out <= p_calc;
                q_out <= q_calc;
            end
            if (accept) begin
                pmis_q <= 1'b0;
                qmis_q <= 1'b0;
            end else if (beat_take && checks) begin
                pmis_q <= pmis_q | (want_p && (p_calc != beat_oldp));
                qmis_q <= qmis_q | (want_q && (q_calc != beat_oldq));
            end
        end
    end

    // state-decoded outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   begin busy = 1'b0; done = 1'b0; end
            ST_STREAM: begin busy = 1'b1; done = 1'b0; end
            ST_FINISH: begin busy = 1'b1; done = 1'b1; end
            default:   begin busy = 1'b0; done = 1'b0; end
        endcase
        err        = done && err_q;
        p_mismatch = done && pmis_q;
        q_mismatch = done && qmis_q;
    end

endmodule

// File: rtl/pq_parity_gen_chk.sv
module pq_parity_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [7:0] cmd_op,
    input logic       busy,
    input logic       p_out_valid,
    input logic       q_out_valid,
    input logic       done,
    input logic       err,
    input logic       p_mismatch,
    input logic       q_mismatch
);

    logic [7:0] op_sh;

    always_ff @(posedge clk) begin
        if (!rst_n)                 op_sh <= 8'h00;
        else if (cmd_valid && !busy) op_sh <= cmd_op;
    end

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!p_out_valid && !q_out_valid));

    p_obsolete_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op == 8'h85 || cmd_op == 8'h86)) |=> (done && err));

    p_flags_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (err || p_mismatch || q_mismatch) |-> done);

    p_check_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (op_sh == 8'h88 || op_sh == 8'h8A)) |-> (!p_out_valid && !q_out_valid));

    p_xor_no_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_sh == 8'h87) |-> !q_out_valid);

endmodule

bind pq_parity_gen pq_parity_gen_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .busy        (busy),
    .p_out_valid (p_out_valid),
    .q_out_valid (q_out_valid),
    .done        (done),
    .err         (err),
    .p_mismatch  (p_mismatch),
    .q_mismatch  (q_mismatch)
);

// File: tb/pq_parity_gen_test.sv
module pq_parity_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC  = 8;
    localparam int LANES = 2;
    localparam int CNTW  = 3;
    localparam int BW    = LANES * 8;
    localparam int CW    = NSRC * 8;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cmd_valid, cmd_pdis, cmd_qdis;
    logic [7:0]         cmd_op, cmd_upd_coef;
    logic [CNTW-1:0]    cmd_cnt;
    logic [CW-1:0]      cmd_coef;
    logic               busy;
    logic               beat_valid, beat_last;
    logic [NSRC*BW-1:0] src;
    logic [BW-1:0]      oldp, oldq;
    logic [BW-1:0]      p_out, q_out;
    logic               p_out_valid, q_out_valid, done, err, p_mismatch, q_mismatch;

    pq_parity_gen #(.NSRC(NSRC), .LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_cnt(cmd_cnt),
        .cmd_pdis(cmd_pdis), .cmd_qdis(cmd_qdis), .cmd_coef(cmd_coef),
        .cmd_upd_coef(cmd_upd_coef), .busy(busy),
        .beat_valid(beat_valid), .beat_last(beat_last), .beat_src(src),
        .beat_oldp(oldp), .beat_oldq(oldq),
        .p_out(p_out), .p_out_valid(p_out_valid),
        .q_out(q_out), .q_out_valid(q_out_valid),
        .done(done), .err(err), .p_mismatch(p_mismatch), .q_mismatch(q_mismatch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [CW-1:0] cur_coef;
    int cur_cnt;
    bit cur_fold;
    localparam logic [CW-1:0] GEN_COEF = 64'h8E_03_1D_FF_02_47_B5_01;

    function automatic logic [7:0] xt(input logic [7:0] x);
        return {x[6:0], 1'b0} ^ (x[7] ? 8'h1D : 8'h00);
    endfunction

    // Horner form, most significant coefficient bit first
    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r;
        r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = xt(r);
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int s);
        int v;
        v = s * 73 + (s >> 5) * 19 + 90;
        return v[7:0];
    endfunction

    function automatic logic [BW-1:0] ref_p();
        logic [BW-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[l*8 +: 8] = cur_fold ? oldp[l*8 +: 8] : 8'h00;
            for (int s = 0; s <= cur_cnt; s++) r[l*8 +: 8] ^= src[(s*LANES+l)*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [BW-1:0] ref_q();
        logic [BW-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[l*8 +: 8] = cur_fold ? oldq[l*8 +: 8] : 8'h00;
            for (int s = 0; s <= cur_cnt; s++)
                r[l*8 +: 8] ^= gmul(src[(s*LANES+l)*8 +: 8], cur_coef[s*8 +: 8]);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [7:0] op, input int cnt, input bit pd, input bit qd,
                         input logic [CW-1:0] cf, input logic [7:0] uc);
        while (busy) @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_cnt = CNTW'(cnt);
        cmd_pdis = pd; cmd_qdis = qd; cmd_coef = cf; cmd_upd_coef = uc;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic beat(input bit last);
        beat_valid = 1'b1;
        beat_last  = last;
        @(posedge clk);
        @(negedge clk);
        beat_valid = 1'b0;
        beat_last  = 1'b0;
    endtask

    task automatic fill(input int seed);
        for (int s = 0; s < NSRC; s++)
            for (int l = 0; l < LANES; l++)
                src[(s*LANES+l)*8 +: 8] = pat(seed*16 + s*LANES + l);
        for (int l = 0; l < LANES; l++) begin
            oldp[l*8 +: 8] = pat(seed*5 + l + 300);
            oldq[l*8 +: 8] = pat(seed*7 + l + 500);
        end
    endtask

    task automatic gen_run(input logic [7:0] op, input int cnt, input bit pd, input bit qd,
                           input int nb, input string req);
        bit pv, qv;
        logic [BW-1:0] ep, eq;
        cur_fold = (op == 8'h8B);
        cur_cnt  = cur_fold ? 0 : cnt;
        cur_coef = cur_fold ? {{(CW-8){1'b0}}, 8'h5C} : GEN_COEF;
        pv = !pd;
        qv = !qd && (op != 8'h87);
        issue(op, cnt, pd, qd, GEN_COEF, 8'h5C);
        for (int b = 0; b < nb; b++) begin
            fill(b + cnt * 11 + int'(op));
            ep = ref_p();
            eq = ref_q();
            beat(b == nb - 1);
            check(p_out_valid == pv, {req, " R5 p valid"}, p_out_valid, pv);
            check(q_out_valid == qv, {req, " R5 q valid"}, q_out_valid, qv);
            if (pv) check(p_out == ep, {req, " P value"}, p_out, ep);
            if (qv) check(q_out == eq, {req, " Q value"}, q_out, eq);
            if (b == nb - 1) check(done && !err, "R9 done with last beat", {done, err}, 2'b10);
            else check(!done && busy, "R9 busy while streaming", {done, busy}, 2'b01);
        end
    endtask

    task automatic val_run(input logic [7:0] op, input int cnt, input bit pd, input bit qd,
                           input int badp, input int badq);
        bit ep, eq;
        cur_fold = 1'b0;
        cur_cnt  = cnt;
        cur_coef = GEN_COEF;
        issue(op, cnt, pd, qd, GEN_COEF, 8'h00);
        for (int b = 0; b < 4; b++) begin
            fill(b + 40 + cnt);
            oldp = ref_p() ^ ((b == badp) ? BW'(1) : BW'(0));
            oldq = ref_q() ^ ((b == badq) ? BW'(16'h0100) : BW'(0));
            beat(b == 3);
            check(!p_out_valid && !q_out_valid, "R6 check writes nothing",
                  {p_out_valid, q_out_valid}, 2'b00);
        end
        ep = (badp >= 0) && !pd;
        eq = (badq >= 0) && !qd && (op == 8'h8A);
        check(done && !err, "R6 check completes", {done, err}, 2'b10);
        check(p_mismatch == ep, "R6 p_mismatch", p_mismatch, ep);
        check(q_mismatch == eq, "R6 q_mismatch", q_mismatch, eq);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 8'h00; cmd_cnt = '0;
        cmd_pdis = 1'b0; cmd_qdis = 1'b0; cmd_coef = '0; cmd_upd_coef = 8'h00;
        beat_valid = 1'b0; beat_last = 1'b0; src = '0; oldp = '0; oldq = '0;
        cur_coef = '0; cur_cnt = 0; cur_fold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check({busy, done, err, p_mismatch, q_mismatch, p_out_valid, q_out_valid} == 7'b0,
              "R1 reset outputs", {busy, done, err, p_mismatch, q_mismatch, p_out_valid, q_out_valid}, 0);

        // R2 and R4: XOR parity at every count, junk on unused sources
        for (int c = 0; c < NSRC; c++) gen_run(8'h87, c, 1'b0, 1'b0, 4, "R2 R4");
        // R3 and R4: P+Q at every count
        for (int c = 0; c < NSRC; c++) gen_run(8'h89, c, 1'b0, 1'b0, 4, "R3 R4");
        // R5 single suppression
        gen_run(8'h89, 7, 1'b1, 1'b0, 3, "R5 pdis");
        gen_run(8'h89, 7, 1'b0, 1'b1, 3, "R5 qdis");
        // R7 update ignores count
        gen_run(8'h8B, 5, 1'b0, 1'b0, 4, "R7");
        gen_run(8'h8B, 5, 1'b1, 1'b0, 2, "R7 pdis");

        // R5 nothing to write: immediate completion
        issue(8'h89, 3, 1'b1, 1'b1, GEN_COEF, 8'h00);
        check(done && !err && !p_out_valid && !q_out_valid, "R5 empty PQ completes at once",
              {done, err, p_out_valid, q_out_valid}, 4'b1000);
        issue(8'h87, 3, 1'b1, 1'b0, GEN_COEF, 8'h00);
        check(done && !err, "R5 empty XOR completes at once", {done, err}, 2'b10);
        @(negedge clk);
        check(!busy, "R9 idle after done", busy, 0);

        // R6 checks
        val_run(8'h88, 3, 1'b0, 1'b0, -1, -1);
        val_run(8'h88, 3, 1'b0, 1'b0, 1, -1);
        val_run(8'h88, 7, 1'b0, 1'b0, -1, 2);
        val_run(8'h8A, 5, 1'b0, 1'b0, -1, -1);
        val_run(8'h8A, 5, 1'b0, 1'b0, 2, -1);
        val_run(8'h8A, 5, 1'b0, 1'b0, -1, 0);
        val_run(8'h8A, 5, 1'b1, 1'b0, 1, -1);
        val_run(8'h8A, 5, 1'b0, 1'b1, -1, 1);
        val_run(8'h8A, 0, 1'b0, 1'b0, 3, 3);

        // R8 rejected opcodes
        foreach (GEN_COEF[i]) begin
            if (i < 4) begin
                logic [7:0] bop;
                bop = (i == 0) ? 8'h85 : (i == 1) ? 8'h86 : (i == 2) ? 8'h00 : 8'h8C;
                issue(bop, 2, 1'b0, 1'b0, GEN_COEF, 8'h00);
                check(done && err && !p_out_valid && !q_out_valid, "R8 rejected opcode",
                      {done, err, p_out_valid, q_out_valid}, 4'b1100);
                @(negedge clk);
                // R10 beat while idle
                fill(i);
                beat(1'b1);
                check(!busy && !p_out_valid && !q_out_valid, "R10 idle beat ignored",
                      {busy, p_out_valid, q_out_valid}, 3'b000);
            end
        end

        // R9 command while busy is ignored
        cur_fold = 1'b0; cur_cnt = 2; cur_coef = GEN_COEF;
        issue(8'h89, 2, 1'b0, 1'b0, GEN_COEF, 8'h00);
        fill(77);
        cmd_valid = 1'b1; cmd_op = 8'h85;
        beat(1'b0);
        cmd_valid = 1'b0;
        check(p_out_valid && p_out == ref_p(), "R9 stream continues", p_out, ref_p());
        fill(78);
        beat(1'b1);
        check(done && !err, "R9 busy command ignored", {done, err}, 2'b10);
        check(q_out == ref_q(), "R3 Q after ignored command", q_out, ref_q());

        // R7 exhaustive: every coefficient times every byte
        for (int c = 0; c < 256; c++) begin
            cur_fold = 1'b1; cur_cnt = 0; cur_coef = {{(CW-8){1'b0}}, 8'(c)};
            issue(8'h8B, 6, 1'b0, 1'b0, {CW{1'b1}}, 8'(c));
            for (int k = 0; k < 128; k++) begin
                fill(k + c);
                src[7:0]  = 8'(2*k);
                src[15:8] = 8'(2*k + 1);
                beat(k == 127);
                check(p_out == ref_p(), "R7 sweep P", p_out, ref_p());
                check(q_out == ref_q(), "R7 sweep Q", q_out, ref_q());
            end
            check(done && !err, "R7 sweep done", {done, err}, 2'b10);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule